// File: doc/BRIEF.md
# Scrolling Word Ticker for Six Seven-Segment Digits

This block shows the word "HELLO" followed by one blank position on six seven-segment digit outputs, and moves it one digit to the left at a fixed interval. At 50 MHz with the default divide value, that interval is one second. Each digit is driven directly by a 7-bit segment register. The six registers form a shift chain that runs from the rightmost digit (`seg0`) to the leftmost digit (`seg5`).

A prescaler makes a one-cycle tick, and the chain moves only on that tick. For the first six ticks after reset, a small controller feeds the characters H, E, L, L, O and blank, in that order, into the rightmost register. After that, the controller connects the leftmost register back to the rightmost one. From then on, the six characters circulate without end, and the word comes back in from the right once it has left on the left. Every register uses the single input clock, and reset is synchronous and active-low.

Top module: `ticker_scroll`

## Requirements
- R1: While `rstN` is low at a rising clock edge, all six segment outputs become 7'b1111111 (blank, all segments off) after that edge.
- R2: Counting rising edges with `rstN` high from 1 after the release of reset, the outputs change only at edge numbers that are multiples of `CLK_DIV`. At every other edge they hold their value.
- R3: The n-th shift after reset, for n from 1 to 6, places the n-th character of the sequence H, E, L, L, O, blank onto `seg0`.
- R4: On every shift, each of `seg1` to `seg5` takes the value that its right-hand neighbour (`seg0` to `seg4`) held before the shift.
- R5: From the seventh shift onward, `seg0` takes the value that `seg5` held before the shift. The six characters therefore rotate with a period of six shifts and never stop.
- R6: Segments are active-low in bit order {g,f,e,d,c,b,a}, with bit 6 being g. The codes are H = 7'b0001001, E = 7'b0000110, L = 7'b1000111, O = 7'b1000000 and blank = 7'b1111111.
- R7: A reset applied during the ring phase blanks the display and restarts loading from H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single system clock for every register |
| rstN | input | 1 | Synchronous active-low reset |
| seg0 | output | 7 | Rightmost digit segments, active-low {g..a} |
| seg1 | output | 7 | Digit 1 segments |
| seg2 | output | 7 | Digit 2 segments |
| seg3 | output | 7 | Digit 3 segments |
| seg4 | output | 7 | Digit 4 segments |
| seg5 | output | 7 | Leftmost digit segments |

## Verification
The hardest behaviour to reach from the ports is the handover from loading to recirculation. In that step the value on `seg0` stops coming from the fixed word and starts coming from `seg5`. A reset issued while the ring is running must also put the controller back into loading. The bench shrinks the divide value so that twenty ticks run past the handover more than twice, then pulls reset in the middle of the rotation and follows the reload through the handover a second time. At every clock it checks that nothing moves between ticks.

// File: rtl/ticker_pkg.sv
package ticker_pkg;
  localparam int SEG_W      = 7;
  localparam int NUM_DIGITS = 6;
  localparam int WORD_LEN   = 6;
  localparam int IDX_W      = $clog2(WORD_LEN);

  // Active-low, bit order {g,f,e,d,c,b,a}
  localparam logic [SEG_W-1:0] SEG_H     = 7'b0001001;
  localparam logic [SEG_W-1:0] SEG_E     = 7'b0000110;
  localparam logic [SEG_W-1:0] SEG_L     = 7'b1000111;
  localparam logic [SEG_W-1:0] SEG_O     = 7'b1000000;
  localparam logic [SEG_W-1:0] SEG_BLANK = 7'b1111111;

  typedef enum logic {ST_LOAD, ST_LOOP} tickerState_t;

  typedef struct packed {
    logic             shift;
    logic             recirc;
    logic [SEG_W-1:0] newSeg;
  } tickerStrobe_t;

  function automatic logic [SEG_W-1:0] wordChar(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    wordChar = SEG_H;
      3'd1:    wordChar = SEG_E;
      3'd2:    wordChar = SEG_L;
      3'd3:    wordChar = SEG_L;
      3'd4:    wordChar = SEG_O;
      default: wordChar = SEG_BLANK;
    endcase
  endfunction
endpackage

// File: rtl/ticker_prescaler.sv
module ticker_prescaler #(
  parameter int CLK_DIV = 50_000_000
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] count;

  assign tick = (count == LAST);

  always_ff @(posedge clk) begin
    if (!rstN)      count <= '0;
    else if (tick)  count <= '0;
    else            count <= count + 1'b1;
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    count <= LAST);  // R2

  generate
    if (CLK_DIV > 1) begin : g_tickGap
      AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);  // R2
    end
  endgenerate
endmodule

// File: rtl/ticker_ctrl.sv
module ticker_ctrl
  import ticker_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  output tickerStrobe_t strb
);
  tickerState_t     state, stateNext;
  logic [IDX_W-1:0] loadIdx, loadIdxNext;

  always_comb begin
    stateNext   = state;
    loadIdxNext = loadIdx;
    strb.shift  = tick;
    strb.recirc = (state == ST_LOOP);
    strb.newSeg = wordChar(loadIdx);
    case (state)
      ST_LOAD: begin
        if (tick) begin
          if (loadIdx == IDX_W'(WORD_LEN - 1)) begin
            stateNext   = ST_LOOP;
            loadIdxNext = '0;
          end else begin
            loadIdxNext = loadIdx + 1'b1;
          end
        end
      end
      default: stateNext = ST_LOOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      loadIdx <= '0;
    end else begin
      state   <= stateNext;
      loadIdx <= loadIdxNext;
    end
  end

  AST_LOOP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_LOOP |=> state == ST_LOOP);  // R5

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    loadIdx < IDX_W'(WORD_LEN));  // R3

  AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(state) && $stable(loadIdx));  // R2
endmodule

// File: rtl/ticker_shift.sv
module ticker_shift
  import ticker_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  tickerStrobe_t                       strb,
  output logic [NUM_DIGITS-1:0][SEG_W-1:0]    digits
);
  logic [SEG_W-1:0] entry;

  assign entry = strb.recirc ? digits[NUM_DIGITS-1] : strb.newSeg;

  always_ff @(posedge clk) begin
    if (!rstN)           digits[0] <= SEG_BLANK;
    else if (strb.shift) digits[0] <= entry;
  end

  generate
    for (genvar i = 1; i < NUM_DIGITS; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN)           digits[i] <= SEG_BLANK;
        else if (strb.shift) digits[i] <= digits[i-1];
      end
    end
  endgenerate

  AST_CHAIN_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> digits[NUM_DIGITS-1] == $past(digits[NUM_DIGITS-2]));  // R4

  AST_RING_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift && strb.recirc |=> digits[0] == $past(digits[NUM_DIGITS-1]));  // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(digits));  // R2
endmodule

// File: rtl/ticker_scroll.sv
module ticker_scroll
  import ticker_pkg::*;
#(
  parameter int CLK_DIV = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  output logic [6:0] seg0,
  output logic [6:0] seg1,
  output logic [6:0] seg2,
  output logic [6:0] seg3,
  output logic [6:0] seg4,
  output logic [6:0] seg5
);
  logic                             tick;
  tickerStrobe_t                    strb;
  logic [NUM_DIGITS-1:0][SEG_W-1:0] digits;

  ticker_prescaler #(.CLK_DIV(CLK_DIV)) u_prescaler (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  ticker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb)
  );

  ticker_shift u_shift (
    .clk(clk), .rstN(rstN), .strb(strb), .digits(digits)
  );

  assign seg0 = digits[0];
  assign seg1 = digits[1];
  assign seg2 = digits[2];
  assign seg3 = digits[3];
  assign seg4 = digits[4];
  assign seg5 = digits[5];

  AST_RESET_BLANK: assert property (@(posedge clk)
    !rstN |=> digits == {NUM_DIGITS{SEG_BLANK}});  // R1
endmodule

// File: tb/ticker_scroll_tb.sv
module ticker_scroll_tb_top;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] seg0, seg1, seg2, seg3, seg4, seg5;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  bit monActive = 1'b0;

  logic [41:0] expQ[$];

  always #2.5 clk = ~clk;

  ticker_scroll #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN),
    .seg0(seg0), .seg1(seg1), .seg2(seg2),
    .seg3(seg3), .seg4(seg4), .seg5(seg5)
  );

  // R6: code values stated in the requirements
  function automatic logic [6:0] wordAt(input int k);
    case (k % 6)
      0: wordAt = 7'b0001001;
      1: wordAt = 7'b0000110;
      2: wordAt = 7'b1000111;
      3: wordAt = 7'b1000111;
      4: wordAt = 7'b1000000;
      default: wordAt = 7'b1111111;
    endcase
  endfunction

  // Display after n shifts, packed {seg5..seg0}
  function automatic logic [41:0] expDisplay(input int n);
    logic [41:0] v;
    for (int j = 0; j < 6; j++) begin
      if (n - 1 - j < 0) v[j*7 +: 7] = 7'b1111111;
      else               v[j*7 +: 7] = wordAt(n - 1 - j);
    end
    return v;
  endfunction

  function automatic logic [41:0] curDisplay();
    return {seg5, seg4, seg3, seg2, seg1, seg0};
  endfunction

  task automatic check(input string req, input logic [41:0] act, input logic [41:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: pushes the expected display for each shift
  task automatic pushExpect(input int count);
    for (int n = 1; n <= count; n++) expQ.push_back(expDisplay(n));
  endtask

  task automatic waitDrained();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops expected values at shift edges, checks hold elsewhere
  int cyc = 0;
  int shiftNo = 0;
  logic [41:0] prevDisp = '1;

  always @(negedge clk) begin
    if (!rstN || !monActive) begin
      cyc = 0;
      shiftNo = 0;
      prevDisp = '1;
    end else begin
      cyc++;
      if (cyc % DIV == 0) begin
        shiftNo++;
        if (expQ.size() == 0) begin
          nChecks++;
          nFails++;
          $display("FAIL R2 actual=shift with empty queue expected=queued item");
        end else begin
          logic [41:0] e;
          e = expQ.pop_front();
          if (shiftNo <= 6) check("R3 R4 load", curDisplay(), e);
          else              check("R5 R4 ring", curDisplay(), e);
        end
      end else begin
        check("R2 hold between ticks", curDisplay(), prevDisp);
      end
      prevDisp = curDisplay();
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset blank", curDisplay(), {6{7'b1111111}});

    // Phase 1: load, then more than two full rotations
    pushExpect(20);
    monActive = 1'b1;
    #1 rstN = 1'b1;
    // Check the R6 codes at the moment loading completes
    repeat (6 * DIV) @(negedge clk);
    check("R6 seg5 H", {35'd0, seg5}, {35'd0, 7'b0001001});
    check("R6 seg4 E", {35'd0, seg4}, {35'd0, 7'b0000110});
    check("R6 seg3 L", {35'd0, seg3}, {35'd0, 7'b1000111});
    check("R6 seg1 O", {35'd0, seg1}, {35'd0, 7'b1000000});
    check("R6 seg0 blank", {35'd0, seg0}, {35'd0, 7'b1111111});
    waitDrained();

    // Phase 2: reset in the middle of the ring, then reload (R7)
    repeat (3) @(negedge clk);
    #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 R1 mid-ring reset blank", curDisplay(), {6{7'b1111111}});
    expQ.delete();
    pushExpect(9);
    #1 rstN = 1'b1;
    waitDrained();

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule